// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block gathers level-sensitive interrupt lines and presents them to a processor as two request outputs: a normal request and a fast request. Both outputs look at the same vector of active lines, but each passes it through its own enable mask. Software never writes a mask directly. One word address ORs bits into a mask and a second word address removes bits from it. A software-raised interrupt shares source 0 with external line 0, so firmware can trigger that source without any external hardware.

The top level holds two controller units in a cascade on one word-addressed register bus. A bank-select bit picks the unit. The secondary unit's normal request is ORed into one input line of the primary unit, which is line 26 by default. The primary unit drives the processor's normal and fast request pins. The secondary unit's fast request is brought out on its own pin. There is no prioritisation, no vectoring and no edge detection: each output is the OR of the active sources that are enabled for it.

Every bus access receives a response one cycle later. The response carries the read data and a flag that marks an access to a word that does not exist for that direction.

Top module: `intc_cascade`

## Requirements
- R1: The raw level vector of a unit equals its input lines, with software latch ORed into bit 0. A read of word 1 or word 9 returns it.
- R2: The normal request output is high exactly when (level AND normal enable) is nonzero. It is registered, so it follows a change one clock later.
- R3: The fast request output is high exactly when (level AND fast enable) is nonzero. It is registered the same way and is independent of the normal enable.
- R4: A write to word 2 ORs the data into the normal enable. A write to word 3 clears the enable bits that are 1 in the data. Words 10 and 11 do the same for the fast enable. Reads of words 2 and 10 return the two enables.
- R5: A write to word 4 sets the software latch and a write to word 5 clears it, but each has an effect only when data bit 0 is 1. A read of word 4 returns level bit 0 in bit 0 and zero in the other bits.
- R6: A read of word 0 returns level AND normal enable. A read of word 8 returns level AND fast enable.
- R7: The response error flag is set for a read of words 3, 5, 11 or of any word not listed in R1, R4, R5 or R6, and such a read returns zero. It is also set for a write to words 0, 1, 8, 9 or to any word not listed in R4 or R5, and such a write changes no state. Valid accesses return the flag clear.
- R8: Reset clears both enables, the software latch, the request outputs and the response outputs.
- R9: Bank-select 0 addresses the primary unit and 1 the secondary unit. The secondary unit's normal request is ORed into the primary unit's input line CASC_LINE, and its fast request drives the secondary fast output.
- R10: Every access that is presented in one cycle gets exactly one response, with the response valid flag set in the next cycle. The valid flag is low when no access was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | 0 = primary unit, 1 = secondary unit |
| req_word | input | 4 | Word address inside the unit |
| req_wdata | input | NSRC (32) | Write data |
| rsp_valid | output | 1 | Response for last cycle's access |
| rsp_err | output | 1 | Access to a word that does not exist for that direction |
| rsp_rdata | output | NSRC (32) | Read data, zero for writes and bad reads |
| pri_src | input | NSRC (32) | Interrupt lines of the primary unit |
| sec_src | input | NSRC (32) | Interrupt lines of the secondary unit |
| irq_o | output | 1 | Primary normal request |
| fiq_o | output | 1 | Primary fast request |
| sec_fiq_o | output | 1 | Secondary fast request |

## Verification
The bench builds the block with its defaults: 32 sources and the cascade on line 26. At that width, all-ones set and clear patterns reach every mask bit, including the top bit. Line 26 carries the cascade, so the bench can observe the secondary request as a bit in the primary raw and status words, in addition to seeing it on the request pin. The bench runs the software latch against external line 0, so the OR on bit 0 is checked in both directions.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned WORD_AW = 4;

    typedef enum logic [3:0] {
        OP_IRQ_STAT,
        OP_RAW,
        OP_IRQ_EN,
        OP_IRQ_EN_CLR,
        OP_SW_SET,
        OP_SW_CLR,
        OP_FIQ_STAT,
        OP_FIQ_RAW,
        OP_FIQ_EN,
        OP_FIQ_EN_CLR,
        OP_NONE
    } op_e;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
        op_e  op;
    } dec_t;

    // Word index to operation; indices are part of the bus contract.
    function automatic dec_t decode_word(input logic [WORD_AW-1:0] w);
        dec_t d;
        d = '{rd_ok: 1'b0, wr_ok: 1'b0, op: OP_NONE};
        case (w)
            4'd0:  d = '{rd_ok: 1'b1, wr_ok: 1'b0, op: OP_IRQ_STAT};
            4'd1:  d = '{rd_ok: 1'b1, wr_ok: 1'b0, op: OP_RAW};
            4'd2:  d = '{rd_ok: 1'b1, wr_ok: 1'b1, op: OP_IRQ_EN};
            4'd3:  d = '{rd_ok: 1'b0, wr_ok: 1'b1, op: OP_IRQ_EN_CLR};
            4'd4:  d = '{rd_ok: 1'b1, wr_ok: 1'b1, op: OP_SW_SET};
            4'd5:  d = '{rd_ok: 1'b0, wr_ok: 1'b1, op: OP_SW_CLR};
            4'd8:  d = '{rd_ok: 1'b1, wr_ok: 1'b0, op: OP_FIQ_STAT};
            4'd9:  d = '{rd_ok: 1'b1, wr_ok: 1'b0, op: OP_FIQ_RAW};
            4'd10: d = '{rd_ok: 1'b1, wr_ok: 1'b1, op: OP_FIQ_EN};
            4'd11: d = '{rd_ok: 1'b0, wr_ok: 1'b1, op: OP_FIQ_EN_CLR};
            default: d = '{rd_ok: 1'b0, wr_ok: 1'b0, op: OP_NONE};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (set_en) begin
            mask <= mask | bits;
        end else if (clr_en) begin
            mask <= mask & ~bits;
        end
    end

    AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((mask & $past(bits)) == $past(bits))) else $error("set lost bits"); // R4
    AST_CLR_DROPS_BITS: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> ((mask & $past(bits)) == '0)) else $error("clear kept bits"); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(mask)) else $error("mask drifted"); // R4

endmodule

// File: rtl/intc_unit.sv
module intc_unit
    import intc_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [WORD_AW-1:0] acc_word,
    input  logic [NSRC-1:0]    acc_wdata,
    input  logic [NSRC-1:0]    src,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [NSRC-1:0]    rsp_rdata,
    output logic               irq,
    output logic               fiq
);

    localparam int unsigned NMASK = 2;

    dec_t dec;
    logic wr_go;
    logic rd_go;
    logic sw_q;
    logic [NSRC-1:0] level;
    logic [NSRC-1:0] en_vec [NMASK];
    logic [NSRC-1:0] irq_en;
    logic [NSRC-1:0] fiq_en;
    logic [NSRC-1:0] rd_val;

    assign dec   = decode_word(acc_word);
    assign wr_go = acc_valid &  acc_write & dec.wr_ok;
    assign rd_go = acc_valid & ~acc_write & dec.rd_ok;

    // Software latch, acts only when data bit 0 is set.
    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q <= 1'b0;
        end else if (wr_go && acc_wdata[0]) begin
            if (dec.op == OP_SW_SET) begin
                sw_q <= 1'b1;
            end else if (dec.op == OP_SW_CLR) begin
                sw_q <= 1'b0;
            end
        end
    end

    assign level = src | {{(NSRC-1){1'b0}}, sw_q};

    for (genvar g = 0; g < NMASK; g++) begin : g_mask
        localparam op_e SET_OP = (g == 0) ? OP_IRQ_EN     : OP_FIQ_EN;
        localparam op_e CLR_OP = (g == 0) ? OP_IRQ_EN_CLR : OP_FIQ_EN_CLR;
        intc_mask_bank #(.W(NSRC)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .set_en (wr_go && (dec.op == SET_OP)),
            .clr_en (wr_go && (dec.op == CLR_OP)),
            .bits   (acc_wdata),
            .mask   (en_vec[g])
        );
    end

    assign irq_en = en_vec[0];
    assign fiq_en = en_vec[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
            fiq <= 1'b0;
        end else begin
            irq <= |(level & irq_en);
            fiq <= |(level & fiq_en);
        end
    end

    always_comb begin
        case (dec.op)
            OP_IRQ_STAT: rd_val = level & irq_en;
            OP_RAW:      rd_val = level;
            OP_IRQ_EN:   rd_val = irq_en;
            OP_SW_SET:   rd_val = {{(NSRC-1){1'b0}}, level[0]};
            OP_FIQ_STAT: rd_val = level & fiq_en;
            OP_FIQ_RAW:  rd_val = level;
            OP_FIQ_EN:   rd_val = fiq_en;
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_err   <= acc_valid & (acc_write ? ~dec.wr_ok : ~dec.rd_ok);
            rsp_rdata <= rd_go ? rd_val : '0;
        end
    end

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq == |($past(level) & $past(irq_en)))) else $error("irq mismatch"); // R2
    AST_FIQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (fiq == |($past(level) & $past(fiq_en)))) else $error("fiq mismatch"); // R3
    AST_SW_NEEDS_BIT0: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !acc_wdata[0]) |=> $stable(sw_q)) else $error("latch moved"); // R5
    AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !dec.wr_ok)
        |=> ($stable(irq_en) && $stable(fiq_en) && $stable(sw_q))) else $error("bad write acted"); // R7
    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && !dec.rd_ok) |=> (rsp_err && rsp_rdata == '0)) else $error("bad read"); // R7
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid) else $error("no response"); // R10

endmodule

// File: rtl/intc_cascade.sv
module intc_cascade
    import intc_pkg::*;
#(
    parameter int unsigned NSRC      = 32,
    parameter int unsigned CASC_LINE = 26
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_bank,
    input  logic [WORD_AW-1:0] req_word,
    input  logic [NSRC-1:0]    req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [NSRC-1:0]    rsp_rdata,
    input  logic [NSRC-1:0]    pri_src,
    input  logic [NSRC-1:0]    sec_src,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               sec_fiq_o
);

    localparam int unsigned NUNIT = 2;

    logic [NSRC-1:0]  u_src   [NUNIT];
    logic [NSRC-1:0]  u_rdata [NUNIT];
    logic [NUNIT-1:0] u_rv;
    logic [NUNIT-1:0] u_re;
    logic [NUNIT-1:0] u_irq;
    logic [NUNIT-1:0] u_fiq;

    // Secondary normal request joins the primary on the cascade line.
    assign u_src[0] = pri_src | ({{(NSRC-1){1'b0}}, u_irq[1]} << CASC_LINE);
    assign u_src[1] = sec_src;

    for (genvar g = 0; g < NUNIT; g++) begin : g_unit
        localparam logic BANK = 1'(g);
        intc_unit #(.NSRC(NSRC)) u_unit (
            .clk       (clk),
            .rst       (rst),
            .acc_valid (req_valid && (req_bank == BANK)),
            .acc_write (req_write),
            .acc_word  (req_word),
            .acc_wdata (req_wdata),
            .src       (u_src[g]),
            .rsp_valid (u_rv[g]),
            .rsp_err   (u_re[g]),
            .rsp_rdata (u_rdata[g]),
            .irq       (u_irq[g]),
            .fiq       (u_fiq[g])
        );
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        for (int i = 0; i < NUNIT; i++) begin
            rsp_valid = rsp_valid | u_rv[i];
            rsp_err   = rsp_err   | u_re[i];
            rsp_rdata = rsp_rdata | u_rdata[i];
        end
    end

    assign irq_o     = u_irq[0];
    assign fiq_o     = u_fiq[0];
    assign sec_fiq_o = u_fiq[1];

    AST_ONE_RESPONDER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(u_rv)) else $error("two responders"); // R10
    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid) else $error("spurious response"); // R10
    AST_ERR_IN_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid) else $error("error without response"); // R7

endmodule

// File: tb/intc_cascade_bench.sv
module intc_cascade_bench;

    localparam int unsigned NSRC = 32;
    localparam int unsigned CASC = 26;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic req_bank = 1'b0;
    logic [3:0] req_word = '0;
    logic [NSRC-1:0] req_wdata = '0;
    logic rsp_valid, rsp_err;
    logic [NSRC-1:0] rsp_rdata;
    logic [NSRC-1:0] pri_src = '0;
    logic [NSRC-1:0] sec_src = '0;
    logic irq_o, fiq_o, sec_fiq_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [NSRC-1:0] data;
        logic            err;
        string           tag;
    } exp_t;
    exp_t sb[$];

    logic [NSRC-1:0] m_ien [2];
    logic [NSRC-1:0] m_fen [2];
    logic            m_sw  [2];

    always #2 clk = ~clk;

    intc_cascade #(.NSRC(NSRC), .CASC_LINE(CASC)) u_intc_cascade (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
        .req_word(req_word), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .pri_src(pri_src), .sec_src(sec_src),
        .irq_o(irq_o), .fiq_o(fiq_o), .sec_fiq_o(sec_fiq_o)
    );

    task automatic check(input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NSRC-1:0] sec_level();
        return sec_src | {{(NSRC-1){1'b0}}, m_sw[1]};
    endfunction

    function automatic logic [NSRC-1:0] level_of(input int b);
        logic [NSRC-1:0] v;
        if (b == 1) begin
            v = sec_level();
        end else begin
            v = pri_src | {{(NSRC-1){1'b0}}, m_sw[0]};
            if (|(sec_level() & m_ien[1])) v[CASC] = 1'b1;
        end
        return v;
    endfunction

    // Driver: predicts the response, pushes it, updates the model, drives the bus.
    task automatic acc(input int b, input bit w, input int word, input logic [NSRC-1:0] d, input string tag);
        exp_t e;
        bit rd_ok, wr_ok;
        logic [NSRC-1:0] lv;
        rd_ok = (word inside {0, 1, 2, 4, 8, 9, 10});
        wr_ok = (word inside {2, 3, 4, 5, 10, 11});
        lv = level_of(b);
        e.tag = tag;
        e.err = w ? !wr_ok : !rd_ok;
        e.data = '0;
        if (!w && rd_ok) begin
            case (word)
                0: e.data = lv & m_ien[b];
                1, 9: e.data = lv;
                2: e.data = m_ien[b];
                4: e.data = {{(NSRC-1){1'b0}}, lv[0]};
                8: e.data = lv & m_fen[b];
                10: e.data = m_fen[b];
                default: e.data = '0;
            endcase
        end
        if (w && wr_ok) begin
            case (word)
                2: m_ien[b] = m_ien[b] | d;
                3: m_ien[b] = m_ien[b] & ~d;
                10: m_fen[b] = m_fen[b] | d;
                11: m_fen[b] = m_fen[b] & ~d;
                4: if (d[0]) m_sw[b] = 1'b1;
                5: if (d[0]) m_sw[b] = 1'b0;
                default: ;
            endcase
        end
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_bank = 1'(b);
        req_word = 4'(word); req_wdata = d;
        @(negedge clk);
        check({31'b0, rsp_valid}, 32'd1, {"R10 response next cycle ", tag});
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Monitor: pops the scoreboard whenever a response appears.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                check({31'b0, rsp_valid}, 32'd0, "R10 unexpected response");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_rdata, e.data, {e.tag, " data"});
                check({31'b0, rsp_err}, {31'b0, e.err}, {e.tag, " err"});
            end
        end
    end

    task automatic chk_out(input string tag);
        logic [NSRC-1:0] l0;
        repeat (3) @(negedge clk);
        l0 = level_of(0);
        check({31'b0, irq_o}, {31'b0, |(l0 & m_ien[0])}, {"R2 irq ", tag});
        check({31'b0, fiq_o}, {31'b0, |(l0 & m_fen[0])}, {"R3 fiq ", tag});
        check({31'b0, sec_fiq_o}, {31'b0, |(level_of(1) & m_fen[1])}, {"R9 sec fiq ", tag});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired, all requirements");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++) begin
            m_ien[b] = '0; m_fen[b] = '0; m_sw[b] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check({29'b0, irq_o, fiq_o, sec_fiq_o}, 32'd0, "R8 outputs in reset");
        check({31'b0, rsp_valid}, 32'd0, "R8 response idle in reset");
        rst = 1'b0;
        chk_out("after reset R8");
        acc(0, 0, 2, '0, "R8 irq enable cleared");
        acc(0, 0, 10, '0, "R8 fiq enable cleared");
        acc(0, 0, 4, '0, "R8 soft latch cleared");
        @(negedge clk);
        check({31'b0, rsp_valid}, 32'd0, "R10 idle no response");

        // R1 raw level
        pri_src = 32'h0000_00F0;
        acc(0, 0, 1, '0, "R1 raw word1");
        acc(0, 0, 9, '0, "R1 raw word9");

        // R2 / R4 / R6 normal path
        acc(0, 1, 2, 32'h0000_0030, "R4 irq set");
        chk_out("R2 enabled active");
        acc(0, 0, 0, '0, "R6 irq status");
        acc(0, 0, 2, '0, "R4 irq enable readback");

        // R3 fast path, independent mask
        acc(0, 1, 10, 32'h8000_0080, "R4 fiq set");
        chk_out("R3 fiq on");
        acc(0, 0, 8, '0, "R6 fiq status");
        acc(0, 1, 3, 32'hFFFF_FFFF, "R4 irq clear all");
        chk_out("R4 after irq clear");
        acc(0, 0, 2, '0, "R4 irq enable zero");
        acc(0, 0, 10, '0, "R4 fiq enable unaffected");
        acc(0, 1, 11, 32'h0000_0080, "R4 fiq clear");
        chk_out("R3 fiq off");
        acc(0, 0, 10, '0, "R4 fiq top bit kept");

        // R5 software latch
        pri_src = '0;
        acc(0, 1, 4, 32'h0000_0002, "R5 set without bit0");
        acc(0, 0, 4, '0, "R5 latch still clear");
        acc(0, 1, 4, 32'h0000_0001, "R5 set with bit0");
        acc(0, 0, 4, '0, "R5 latch set");
        acc(0, 0, 1, '0, "R1 raw shows latch");
        acc(0, 1, 2, 32'h0000_0001, "R4 enable src0");
        chk_out("R5 soft irq");
        acc(0, 1, 5, 32'hFFFF_FFFE, "R5 clear without bit0");
        chk_out("R5 latch kept");
        acc(0, 1, 5, 32'h0000_0001, "R5 clear with bit0");
        chk_out("R5 soft irq gone");
        pri_src = 32'h0000_0001;
        chk_out("R1 external line0 alone");
        acc(0, 0, 4, '0, "R1 word4 shows line0");
        pri_src = '0;

        // R7 access errors
        acc(0, 0, 3, '0, "R7 read word3");
        acc(0, 0, 5, '0, "R7 read word5");
        acc(0, 0, 11, '0, "R7 read word11");
        acc(0, 0, 6, '0, "R7 read word6");
        acc(0, 1, 0, 32'hFFFF_FFFF, "R7 write word0");
        acc(0, 1, 1, 32'hFFFF_FFFF, "R7 write word1");
        acc(0, 1, 8, 32'hFFFF_FFFF, "R7 write word8");
        acc(0, 1, 9, 32'hFFFF_FFFF, "R7 write word9");
        acc(0, 1, 12, 32'hFFFF_FFFF, "R7 write word12");
        acc(0, 0, 2, '0, "R7 irq enable unchanged");
        acc(0, 0, 10, '0, "R7 fiq enable unchanged");
        acc(0, 0, 4, '0, "R7 latch unchanged");

        // R9 cascade
        acc(1, 1, 2, 32'h0000_0020, "R9 secondary irq enable");
        acc(0, 1, 2, 32'h0400_0000, "R9 primary enable cascade line");
        sec_src = 32'h0000_0020;
        chk_out("R9 cascade raises irq");
        acc(0, 0, 1, '0, "R9 cascade bit in primary raw");
        acc(0, 0, 0, '0, "R9 cascade bit in primary status");
        acc(1, 0, 1, '0, "R9 secondary raw");
        acc(1, 1, 10, 32'h0000_0020, "R9 secondary fiq enable");
        chk_out("R9 secondary fiq");
        acc(0, 0, 10, '0, "R9 primary fiq enable separate");
        sec_src = '0;
        chk_out("R9 cascade drops");
        acc(1, 1, 4, 32'h0000_0001, "R9 secondary soft set");
        acc(1, 1, 2, 32'h0000_0001, "R9 secondary enable src0");
        chk_out("R9 secondary soft cascades");
        acc(0, 0, 4, '0, "R9 primary latch untouched");

        repeat (3) @(negedge clk);
        check(32'(sb.size()), 32'd0, "R10 all responses seen");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule